// File: doc/BRIEF.md
# Flash read wait-state controller

This block sits between a processor read port and an on-chip nonvolatile array. The array holds two regions: a main flash region and a one-time-programmable (OTP) region. The controller sorts each read address into one of these regions, or into neither. It then stalls the requester for a programmable number of system-clock wait states. At the end of the stall it returns the array word together with a one-cycle valid strobe.

Software sets the wait count through a small configuration port. After reset the count sits at its most conservative setting. The controller only supports plain uncached reads. It keeps no buffer, fetches nothing ahead and never reuses earlier data, so every read that is accepted reaches the array by itself. OTP reads always take one cycle more than main flash reads at the same setting. An address outside both regions gets an error response and never touches the array.

Top module: `flash_wait_ctrl`

## Requirements
- R1: A read accepted for the main flash region (addresses 0x0000 to 0x7FFF) raises `rd_valid` exactly W+1 clock edges after the edge that accepts it. W is the wait count in effect at acceptance.
- R2: A read accepted for the OTP region (addresses 0x8000 to 0x80FF) raises `rd_valid` exactly W+2 edges after acceptance.
- R3: After reset the wait count is 15. A `cfg_we` pulse loads `cfg_wdata` into the count on that edge. `cfg_wait` always shows the current count.
- R4: With a wait count of 0, main flash reads complete in one cycle. A request held high is then accepted on every edge.
- R5: Every accepted in-range read produces exactly one `arr_en` cycle. That cycle carries the request address and `arr_otp` = 1 for OTP. Repeated reads of the same address each reach the array again.
- R6: While a read is outstanding, `rd_ready` is low. Requests seen then cause no array access and no response.
- R7: `rd_valid` lasts one cycle per read. While `rd_valid` is high and `rd_err` is low, `rd_data` equals the word the array returned for that read.
- R8: The wait count is captured when the read is accepted. A write on the accepting edge, or while the read is outstanding, leaves that read's latency unchanged.
- R9: An address in neither region returns `rd_valid` and `rd_err` together one edge after acceptance. No `arr_en` is raised and `rd_data` reads zero.
- R10: A request presented in the cycle where `rd_valid` is high is accepted on the next edge, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Wait-count write strobe |
| cfg_wdata | input | 4 | New wait count |
| cfg_wait | output | 4 | Current wait count |
| rd_req | input | 1 | Read request |
| rd_addr | input | 16 | Read word address |
| rd_ready | output | 1 | High when a new read can be accepted |
| rd_valid | output | 1 | One-cycle response strobe |
| rd_err | output | 1 | Response is an address error |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| arr_en | output | 1 | Array access strobe |
| arr_addr | output | 16 | Array access address |
| arr_otp | output | 1 | Access targets the OTP region |
| arr_rdata | input | 32 | Array output word, available the cycle after `arr_en` |

## Verification
The assertions run on every cycle. They check that each valid strobe lands exactly at the latency fixed at acceptance, using the captured count and the region. They also check that a stalled controller never touches the array, that error responses carry zero data, and that reset restores the worst-case count.

Some behaviours can only be shown by the bench's scenarios. These are:
- that a write during an outstanding read leaves that read alone while later reads pick it up;
- that back-to-back streams at several wait settings keep their throughput;
- that returned words match the addressed region.

// File: rtl/flash_wait_ctrl.sv
module flash_wait_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int WAIT_W      = 4,
  parameter int RESET_WAIT  = 15,
  parameter int FLASH_BASE  = 'h0000,
  parameter int FLASH_WORDS = 'h8000,
  parameter int OTP_BASE    = 'h8000,
  parameter int OTP_WORDS   = 'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WAIT_W-1:0] cfg_wdata,
  output logic [WAIT_W-1:0] cfg_wait,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic              rd_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              arr_en,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              arr_otp,
  input  logic [DATA_W-1:0] arr_rdata
);

  localparam int CNT_W = WAIT_W + 1;

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [WAIT_W-1:0] wait_q;
  logic              valid_q, err_q;
  logic [ADDR_W-1:0] flash_off, otp_off;
  logic              hit_flash, hit_otp, accept;
  logic [CNT_W-1:0]  lat_m1;

  assign flash_off = rd_addr - ADDR_W'(FLASH_BASE);
  assign otp_off   = rd_addr - ADDR_W'(OTP_BASE);
  assign hit_flash = {1'b0, flash_off} < (ADDR_W+1)'(FLASH_WORDS);
  assign hit_otp   = {1'b0, otp_off}   < (ADDR_W+1)'(OTP_WORDS);

  assign accept = rd_req & ~busy;
  assign lat_m1 = {1'b0, wait_q} + CNT_W'(hit_otp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= WAIT_W'(RESET_WAIT);
    else if (cfg_we) wait_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy    <= 1'b0;
          valid_q <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end else if (accept) begin
        if (!(hit_flash || hit_otp)) begin
          valid_q <= 1'b1;
          err_q   <= 1'b1;
        end else if (lat_m1 == '0) begin
          valid_q <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= lat_m1 - CNT_W'(1);
        end
      end
    end
  end

  assign cfg_wait = wait_q;
  assign rd_ready = ~busy;
  assign rd_valid = valid_q;
  assign rd_err   = err_q;
  assign rd_data  = (valid_q && !err_q) ? arr_rdata : '0;
  assign arr_en   = accept & (hit_flash | hit_otp);
  assign arr_addr = rd_addr;
  assign arr_otp  = hit_otp;

endmodule

// File: rtl/flash_wait_ctrl_chk.sv
module flash_wait_ctrl_chk #(
  parameter int WAIT_W     = 4,
  parameter int DATA_W     = 32,
  parameter int RESET_WAIT = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WAIT_W-1:0] cfg_wait,
  input logic              rd_req,
  input logic              rd_ready,
  input logic              rd_valid,
  input logic              rd_err,
  input logic [DATA_W-1:0] rd_data,
  input logic              arr_en,
  input logic              arr_otp
);

  logic             pend;
  logic [WAIT_W+1:0] age, lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      age  <= '0;
      lat  <= '0;
    end else if (arr_en) begin
      pend <= 1'b1;
      age  <= (WAIT_W+2)'(1);
      lat  <= (WAIT_W+2)'(cfg_wait) + (WAIT_W+2)'(1) + (WAIT_W+2)'(arr_otp);
    end else if (rd_valid) begin
      pend <= 1'b0;
    end else if (pend) begin
      age <= age + (WAIT_W+2)'(1);
    end
  end

  // R1 R2 R8
  latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_err |-> pend && age == lat);

  // R6
  stall_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |-> !arr_en);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_req |=> !rd_valid);

  // R10
  ready_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_ready);

  // R9
  err_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_valid && !pend && rd_data == '0);

  // R3
  reset_wait_chk: assert property (@(posedge clk)
    !rst_n |=> cfg_wait == WAIT_W'(RESET_WAIT));

endmodule

bind flash_wait_ctrl flash_wait_ctrl_chk #(
  .WAIT_W(WAIT_W), .DATA_W(DATA_W), .RESET_WAIT(RESET_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .rd_req(rd_req),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_err(rd_err),
  .rd_data(rd_data), .arr_en(arr_en), .arr_otp(arr_otp)
);

// File: tb/flash_wait_ctrl_bench.sv
`timescale 1ns/1ps
module flash_wait_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic [3:0]  cfg_wait;
  logic        rd_req = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_ready, rd_valid, rd_err, arr_en, arr_otp;
  logic [31:0] rd_data;
  logic [15:0] arr_addr;
  logic [31:0] arr_rdata = '0;

  always #4 clk = ~clk;

  flash_wait_ctrl u_flash_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_wait(cfg_wait), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_err(rd_err),
    .rd_data(rd_data), .arr_en(arr_en), .arr_addr(arr_addr),
    .arr_otp(arr_otp), .arr_rdata(arr_rdata)
  );

  function automatic logic [31:0] word_of(input logic [15:0] a, input logic otp);
    return otp ? {~a, a} : {a, a ^ 16'h5A5A};
  endfunction
  function automatic int region(input logic [15:0] a);
    if (a < 16'h8000) return 0;
    if (a < 16'h8100) return 1;
    return 2;
  endfunction

  // array stub: one-cycle synchronous read, output held
  always @(posedge clk) if (arr_en) arr_rdata <= word_of(arr_addr, arr_otp);

  int n_chk = 0, n_fail = 0;
  string cur_req = "R3";
  bit done = 0, started = 0;

  int cyc = 0, vedge = -1, free_at = 0, mw = 15;
  bit exp_err = 0;
  logic [31:0] exp_data = '0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    started = 1;
    if (!rst_n) begin
      mw = 15; vedge = -1; free_at = 0;
    end else begin
      if (rd_req && cyc >= free_at) begin
        int r, l;
        r = region(rd_addr);
        l = (r == 2) ? 1 : mw + 1 + r;
        vedge = cyc + l - 1;
        free_at = cyc + l;
        exp_err = (r == 2);
        exp_data = (r == 2) ? 32'h0 : word_of(rd_addr, r == 1);
      end
      if (cfg_we) mw = cfg_wdata;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (started && !done) begin
      bit ev, er, ee;
      ev = (cyc == vedge);
      er = (cyc + 1 >= free_at);
      ee = rst_n && rd_req && er && region(rd_addr) != 2;
      chk(rd_valid == ev, "rd_valid", 32'(rd_valid), 32'(ev));
      chk(rd_ready == er, "rd_ready", 32'(rd_ready), 32'(er));
      chk(rd_err == (ev && exp_err), "rd_err", 32'(rd_err), 32'(ev && exp_err));
      if (ev) chk(rd_data == exp_data, "rd_data", rd_data, exp_data);
      chk(cfg_wait == 4'(mw), "cfg_wait", 32'(cfg_wait), 32'(mw));
      chk(arr_en == ee, "arr_en", 32'(arr_en), 32'(ee));
      if (ee) begin
        chk(arr_addr == rd_addr, "arr_addr", 32'(arr_addr), 32'(rd_addr));
        chk(arr_otp == (region(rd_addr) == 1), "arr_otp", 32'(arr_otp), 32'(region(rd_addr) == 1));
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // called at a negedge; leaves rd_req high after acceptance edge
  task automatic rd(input logic [15:0] a);
    rd_req = 1'b1;
    rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic idle(input int n);
    rd_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R3"; idle(2);
    cur_req = "R1"; rd(16'h0123); idle(20);
    cur_req = "R2"; rd(16'h8042); idle(20);
    cur_req = "R3"; wr(4'd7); idle(2);
    cur_req = "R4"; wr(4'd0);
    rd(16'h0010); rd(16'h0011); rd(16'h7FFF); rd(16'h0000); idle(3);
    cur_req = "R5"; rd(16'h0200); rd(16'h0200); rd(16'h80FF); rd(16'h80FF); idle(4);
    cur_req = "R10"; wr(4'd3); rd(16'h0300); rd(16'h8001); rd(16'h0301); idle(8);
    cur_req = "R6"; wr(4'd4);
    rd_req = 1'b1; rd_addr = 16'h0400; @(negedge clk);
    rd_addr = 16'h8003; @(negedge clk); rd_addr = 16'hC000; @(negedge clk);
    idle(8);
    cur_req = "R8"; wr(4'd6); rd(16'h0500); rd_req = 1'b0; wr(4'd1); idle(10);
    rd(16'h0501); idle(4);
    rd_req = 1'b1; rd_addr = 16'h8010; cfg_we = 1'b1; cfg_wdata = 4'd9;
    @(negedge clk); cfg_we = 1'b0; idle(14);
    cur_req = "R9"; wr(4'd2);
    rd(16'h8100); rd(16'hFFFF); rd(16'h0600); rd(16'h9000); idle(6);
    cur_req = "R7";
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      a = 16'((i * 40503 + 17) & 16'hFFFF);
      if (i % 3 == 1) a = 16'h8000 | 16'(i);
      if (i % 7 == 0) wr(4'(i % 5));
      rd(a);
      if (i % 4 == 0) idle(i % 3);
    end
    idle(20);
    cur_req = "R1"; wr(4'd15); rd(16'h7000); idle(20);
    report();
  end
endmodule